// File: doc/BRIEF.md
# Adaptive Per-Set Reservation Enable

This controller decides, set by set, whether a cost-aware victim selector may hold a costly block in the least-recently-used frame. A reservation means keeping that costly LRU block and evicting a cheaper block instead. Each set carries a two-bit saturating confidence level and one flag that marks the LRU frame as held. Reservations that pay off raise the level. Reservations that end in eviction lower it. The set is allowed to reserve only while its level is above zero.

While a set is disabled, its shadow tag directory takes on a second job. Each time a costly LRU block is evicted even though a cheaper block was present, that block is logged in the shadow directory. A later access that hits such a logged tag shows that a reservation would have paid off. The controller then flushes the shadow entries of that set and starts reservations again at level 2.

The block takes at most one event per clock on a single event port. An event is either an access or a replacement, and it carries the set index and qualifying flags. The controller answers a combinational lookup for one set, which the victim selector uses. It also emits registered insert and flush commands for the shadow directory. These are plain control pins with no handshake, and every event is taken in the cycle it is presented. `NUM_SETS` must be a power of two. The victim search and the cost depreciation are done elsewhere.

Top module: `adapt_resv_ctrl`

## Requirements
- R1: After reset every set has level 0 and its held flag clear, so `look_en` and `look_rsv` read 0 for every set, and `sh_insert` and `sh_flush` are low.
- R2: `look_en` is 1 exactly when the level of set `look_set` is above zero. `look_rsv` gives that set's held flag, which can only be 1 while the set is enabled.
- R3: An enabled set gets an access (`ev_kind`=0) with `ev_lru`=1 while its flag is set. This is a success: the level rises by one and saturates at 3, and the flag clears.
- R4: An enabled set gets a replacement (`ev_kind`=1) with `ev_lru`=1 while its flag is set. This is a failure: the level falls by one and the flag clears. Falling from 1 disables the set.
- R5: An enabled set gets a replacement with `ev_lru`=0. A non-LRU frame was evicted, so the flag sets.
- R6: A disabled set gets a replacement with `ev_lru`=1 and `ev_cheaper`=1. One cycle later `sh_insert` pulses with `sh_set` equal to the event's set. No other event gives an insert, including any event on an enabled set.
- R7: A disabled set gets an access with `ev_shadow_hit`=1. The level loads the value 2, and one cycle later `sh_flush` pulses with `sh_set` equal to the event's set.
- R8: An enabled set gets an access with `ev_lru`=1. `sh_flush` pulses one cycle later. A shadow hit on an enabled set changes neither the level nor the flag and gives no flush.
- R9: A disabled set ignores accesses with `ev_shadow_hit`=0 and replacements with `ev_lru`=0. Its level stays 0 and its flag stays clear.
- R10: An event changes only the set it names. With `ev_valid`=0 no state changes, and `sh_insert` and `sh_flush` are low the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 1 | 0 = access, 1 = replacement |
| ev_set | input | SET_W | Set index of the event |
| ev_lru | input | 1 | Access: hit on the LRU frame. Replacement: the LRU frame is the victim |
| ev_shadow_hit | input | 1 | Access missed the cache but hit the shadow directory |
| ev_cheaper | input | 1 | Replacement: another frame in the set has a lower cost |
| look_set | input | SET_W | Set queried by the victim selector |
| look_en | output | 1 | Reservations allowed in `look_set` |
| look_rsv | output | 1 | LRU frame of `look_set` is currently held |
| sh_insert | output | 1 | Shadow directory: record the evicted LRU block |
| sh_flush | output | 1 | Shadow directory: invalidate all entries of the set |
| sh_set | output | SET_W | Set index for `sh_insert` / `sh_flush` |

## Verification
A wrong level cannot be seen directly, because only the zero / non-zero split reaches `look_en`. A level that is one too high or too low therefore shows up only later: the set needs a different number of failures to reach disabled. So the bench drives a set into saturation, then counts the failures until `look_en` drops, and does the same after a trigger to confirm the loaded value of 2. A held flag that is stuck or lost shows on `look_rsv` in the very next cycle. A misrouted shadow command shows on `sh_insert`, `sh_flush` or `sh_set` exactly one clock after the event.

// File: rtl/adapt_resv_pkg.sv
package adapt_resv_pkg;

  typedef enum logic {
    EV_ACCESS  = 1'b0,
    EV_REPLACE = 1'b1
  } ev_kind_e;

  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] LVL_TRIG = CNT_W'(2);

  typedef struct packed {
    logic [CNT_W-1:0] lvl;
    logic             held;
  } set_state_t;

  typedef struct packed {
    logic up;
    logic down;
    logic trig;
    logic hold_set;
    logic hold_clr;
    logic sh_ins;
    logic sh_fl;
  } set_act_t;

endpackage

// File: rtl/adapt_sat_ctr.sv
module adapt_sat_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up,
  input  logic         down,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] lvl
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] BOT = '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                      lvl <= BOT;
    else if (load)                   lvl <= load_val;
    else if (up && lvl != TOP)       lvl <= lvl + W'(1);
    else if (down && lvl != BOT)     lvl <= lvl - W'(1);
  end
endmodule

// File: rtl/adapt_set_slot.sv
module adapt_set_slot
  import adapt_resv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       up,
  input  logic       down,
  input  logic       trig,
  input  logic       hold_set,
  input  logic       hold_clr,
  output set_state_t st
);
  logic [CNT_W-1:0] lvl_q;
  logic             held_q;

  adapt_sat_ctr #(.W(CNT_W)) u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .up       (sel & up),
    .down     (sel & down),
    .load     (sel & trig),
    .load_val (LVL_TRIG),
    .lvl      (lvl_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 held_q <= 1'b0;
    else if (sel && hold_clr)   held_q <= 1'b0;
    else if (sel && hold_set)   held_q <= 1'b1;
  end

  assign st.lvl  = lvl_q;
  assign st.held = held_q;
endmodule

// File: rtl/adapt_ev_decode.sv
module adapt_ev_decode
  import adapt_resv_pkg::*;
(
  input  logic       ev_valid,
  input  logic       ev_kind,
  input  logic       ev_lru,
  input  logic       ev_shadow_hit,
  input  logic       ev_cheaper,
  input  set_state_t cur,
  output set_act_t   act
);
  logic     on;
  ev_kind_e kind;

  assign on   = (cur.lvl != '0);
  assign kind = ev_kind_e'(ev_kind);

  always_comb begin
    act = '0;
    if (ev_valid) begin
      unique case (kind)
        EV_ACCESS: begin
          if (on) begin
            if (ev_lru) begin
              act.sh_fl = 1'b1;
              if (cur.held) begin
                act.up       = 1'b1;
                act.hold_clr = 1'b1;
              end
            end
          end else if (ev_shadow_hit) begin
            act.trig  = 1'b1;
            act.sh_fl = 1'b1;
          end
        end
        EV_REPLACE: begin
          if (on) begin
            if (!ev_lru) begin
              act.hold_set = 1'b1;
            end else if (cur.held) begin
              act.down     = 1'b1;
              act.hold_clr = 1'b1;
            end
          end else if (ev_lru && ev_cheaper) begin
            act.sh_ins = 1'b1;
          end
        end
        default: act = '0;
      endcase
    end
  end
endmodule

// File: rtl/adapt_resv_ctrl.sv
module adapt_resv_ctrl
  import adapt_resv_pkg::*;
#(
  parameter  int NUM_SETS = 16,
  localparam int SET_W    = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic             ev_kind,
  input  logic [SET_W-1:0] ev_set,
  input  logic             ev_lru,
  input  logic             ev_shadow_hit,
  input  logic             ev_cheaper,
  input  logic [SET_W-1:0] look_set,
  output logic             look_en,
  output logic             look_rsv,
  output logic             sh_insert,
  output logic             sh_flush,
  output logic [SET_W-1:0] sh_set
);
  set_state_t st_all [NUM_SETS];
  set_state_t cur;
  set_act_t   act;

  assign cur = st_all[ev_set];

  adapt_ev_decode u_dec (
    .ev_valid      (ev_valid),
    .ev_kind       (ev_kind),
    .ev_lru        (ev_lru),
    .ev_shadow_hit (ev_shadow_hit),
    .ev_cheaper    (ev_cheaper),
    .cur           (cur),
    .act           (act)
  );

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    logic sel;
    assign sel = ev_valid && (ev_set == SET_W'(g));
    adapt_set_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .up       (act.up),
      .down     (act.down),
      .trig     (act.trig),
      .hold_set (act.hold_set),
      .hold_clr (act.hold_clr),
      .st       (st_all[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_insert <= 1'b0;
      sh_flush  <= 1'b0;
      sh_set    <= '0;
    end else begin
      sh_insert <= act.sh_ins;
      sh_flush  <= act.sh_fl;
      if (act.sh_ins || act.sh_fl) sh_set <= ev_set;
    end
  end

  assign look_en  = (st_all[look_set].lvl != '0);
  assign look_rsv = st_all[look_set].held;
endmodule

// File: rtl/adapt_resv_chk.sv
module adapt_resv_chk
  import adapt_resv_pkg::*;
#(
  parameter  int NUM_SETS = 16,
  localparam int SET_W    = $clog2(NUM_SETS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_kind,
  input logic [SET_W-1:0] ev_set,
  input logic             ev_lru,
  input logic             ev_shadow_hit,
  input logic             ev_cheaper,
  input logic             look_en,
  input logic             look_rsv,
  input logic             sh_insert,
  input logic             sh_flush,
  input set_state_t       st_all [NUM_SETS]
);
  logic [CNT_W-1:0] ev_lvl;
  logic             ev_held;
  assign ev_lvl  = st_all[ev_set].lvl;
  assign ev_held = st_all[ev_set].held;

  assert_held_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    look_rsv |-> look_en);

  assert_success_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_kind && ev_lru && ev_held && ev_lvl != '0) |=>
      (!st_all[$past(ev_set)].held &&
       st_all[$past(ev_set)].lvl == $past(ev_lvl == 2'd3 ? 2'd3 : ev_lvl + 2'd1)));

  assert_failure_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind && ev_lru && ev_held && ev_lvl != '0) |=>
      (!st_all[$past(ev_set)].held &&
       st_all[$past(ev_set)].lvl == $past(ev_lvl - 2'd1)));

  assert_insert_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sh_insert |-> $past(ev_valid && ev_kind && ev_lru && ev_cheaper && ev_lvl == '0));

  assert_trigger_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_kind && ev_shadow_hit && ev_lvl == '0) |=>
      (sh_flush && st_all[$past(ev_set)].lvl == 2'd2));

  assert_cmd_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh_insert && sh_flush));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> (!sh_insert && !sh_flush));
endmodule

bind adapt_resv_ctrl adapt_resv_chk #(.NUM_SETS(NUM_SETS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_valid      (ev_valid),
  .ev_kind       (ev_kind),
  .ev_set        (ev_set),
  .ev_lru        (ev_lru),
  .ev_shadow_hit (ev_shadow_hit),
  .ev_cheaper    (ev_cheaper),
  .look_en       (look_en),
  .look_rsv      (look_rsv),
  .sh_insert     (sh_insert),
  .sh_flush      (sh_flush),
  .st_all        (st_all)
);

// File: tb/sim_adapt_resv_ctrl.sv
`timescale 1ns/100ps
module sim_adapt_resv_ctrl;
  localparam int NS = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_kind = 1'b0, ev_lru = 1'b0, ev_shadow_hit = 1'b0, ev_cheaper = 1'b0;
  logic [SW-1:0] ev_set = '0, look_set = '0;
  logic look_en, look_rsv, sh_insert, sh_flush;
  logic [SW-1:0] sh_set;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  adapt_resv_ctrl #(.NUM_SETS(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_set(ev_set), .ev_lru(ev_lru), .ev_shadow_hit(ev_shadow_hit),
    .ev_cheaper(ev_cheaper), .look_set(look_set), .look_en(look_en),
    .look_rsv(look_rsv), .sh_insert(sh_insert), .sh_flush(sh_flush),
    .sh_set(sh_set)
  );

  // fields: req | kind | set | lru sh ch | exp insert flush en held
  typedef struct packed {
    logic [3:0] req;
    logic       kind;
    logic [3:0] set;
    logic       lru, sh, ch;
    logic       e_ins, e_fl, e_en, e_rsv;
  } vec_t;

  localparam int NV = 28;
  localparam logic [15:0] VEC [NV] = '{
    16'b0110_1_0011_101_1000, // R6 disabled costly LRU evicted -> insert
    16'b0110_1_0011_100_0000, // R6 no cheaper block -> no insert
    16'b1001_0_0011_000_0000, // R9 plain access while disabled
    16'b1001_0_0011_100_0000, // R9 LRU hit while disabled
    16'b1001_1_0011_001_0000, // R9 non-LRU replacement while disabled
    16'b0111_0_0011_010_0110, // R7 shadow hit triggers level 2 + flush
    16'b0101_1_0011_000_0011, // R5 reservation starts
    16'b0101_1_0011_000_0011, // R5 stays held
    16'b0011_0_0011_100_0110, // R3 success -> 3, flush (R8)
    16'b0101_1_0011_000_0011, // R5
    16'b0011_0_0011_100_0110, // R3 success saturates at 3
    16'b0101_1_0011_000_0011, // R5
    16'b0100_1_0011_101_0010, // R4 failure -> 2, no insert while enabled
    16'b0100_1_0011_101_0010, // R4 LRU evicted, not held -> no change
    16'b0101_1_0011_000_0011, // R5
    16'b0100_1_0011_100_0010, // R4 failure -> 1
    16'b0101_1_0011_000_0011, // R5
    16'b0100_1_0011_100_0000, // R4 failure -> 0, disabled (R3 saturation proven)
    16'b0110_1_0011_101_1000, // R6 disabled again -> insert
    16'b0111_0_0101_010_0110, // R7 trigger on set 5
    16'b0111_0_0011_010_0110, // R7 trigger on set 3
    16'b1000_0_0011_010_0010, // R8 shadow hit while enabled ignored
    16'b1000_0_0011_100_0110, // R8 LRU hit while enabled -> flush only
    16'b0101_1_0011_000_0011, // R5
    16'b0111_1_0011_100_0010, // R7 level was 2 -> 1
    16'b0101_1_0011_000_0011, // R5
    16'b0111_1_0011_100_0000, // R7 level 1 -> 0
    16'b1001_0_0011_100_0000  // R9 disabled LRU hit ignored
  };

  task automatic check(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state of every set
    for (int s = 0; s < NS; s++) begin
      look_set = SW'(s);
      #0.1;
      check("R1 look_en", SW'(look_en), '0);
      check("R1 look_rsv", SW'(look_rsv), '0);
    end
    check("R1 sh_insert", SW'(sh_insert), '0);
    check("R1 sh_flush", SW'(sh_flush), '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      ev_valid = 1'b1; ev_kind = v.kind; ev_set = v.set; look_set = v.set;
      ev_lru = v.lru; ev_shadow_hit = v.sh; ev_cheaper = v.ch;
      @(negedge clk);
      check($sformatf("R%0d v%0d sh_insert", v.req, i), SW'(sh_insert), SW'(v.e_ins));
      check($sformatf("R%0d v%0d sh_flush", v.req, i), SW'(sh_flush), SW'(v.e_fl));
      check($sformatf("R%0d v%0d look_en", v.req, i), SW'(look_en), SW'(v.e_en));
      check($sformatf("R%0d v%0d look_rsv", v.req, i), SW'(look_rsv), SW'(v.e_rsv));
      if (v.e_ins || v.e_fl)
        check($sformatf("R%0d v%0d sh_set", v.req, i), sh_set, v.set);
    end

    // R10 idle cycle carrying a would-be trigger for set 3
    ev_valid = 1'b0; ev_kind = 1'b0; ev_set = 4'd3; ev_shadow_hit = 1'b1; ev_lru = 1'b0;
    look_set = 4'd3;
    @(negedge clk);
    check("R10 idle sh_flush", SW'(sh_flush), '0);
    check("R10 idle look_en set3", SW'(look_en), '0);
    // R10 set 5 untouched by set 3 traffic
    look_set = 4'd5;
    #0.1;
    check("R10 isolation look_en set5", SW'(look_en), 4'd1);
    check("R2 look_rsv set5", SW'(look_rsv), '0);
    look_set = 4'd7;
    #0.1;
    check("R10 isolation look_en set7", SW'(look_en), '0);

    // R1 reset mid-run clears enabled set 5
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look_set = 4'd5;
    #0.1;
    check("R1 mid-run reset look_en set5", SW'(look_en), '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule